// File: doc/BRIEF.md
# Partitioned Direct-Mapped Data Cache

This block is the storage and sequencing core of a byte-addressed, direct-mapped data cache whose lines are divided among software-defined partitions. A load or store from the core arrives with its unperturbed byte address. The same request also carries the results of two neighbouring blocks. One is the partition configuration lookup, which supplies the first line of the partition, the log2 of the virtual line length in physical lines, and the log2 of the sub-word stride in bytes. The other is the address translation, which supplies the partition-relative line and the sub-word index computed from the mask-perturbed address. The cache keeps valid, dirty and tag state per line together with the byte data array.

A request is held by a ready/valid handshake. On a hit the block answers in the cycle after acceptance. On a miss it walks every physical line of the virtual line that contains the target, in order. For each such line it first writes back the line's bytes one at a time if the line is valid and dirty. It then refills the line one byte at a time from a simple memory port, using addresses spaced by the stride and derived only from the unperturbed address. After the fill it answers the request with the miss flag set. Stores allocate on a miss and mark the line dirty.

Top module: `pcache`

## Requirements
- R1: After reset, reqReady is 1, respValid is 0 and memReq is 0, every line is invalid so the first access misses, and memReq is never high while reqReady is high.
- R2: An access hits only when its line (cfgStart + reqPline, modulo the line count) is valid and the stored tag equals the unperturbed address of sub-word 0 of that line, i.e. reqAddr - (reqPword << cfgStLog2); respHit is 1 for a hit and 0 for an access that needed a fill.
- R3: A miss fills all 2^cfgVsLog2 physical lines of the virtual line. The group starts at partition line (reqPline with its low cfgVsLog2 bits cleared) and is filled in increasing line order, each line from sub-word 0 upward, so one miss issues 2^cfgVsLog2 × WORDS memory reads when no line is dirty.
- R4: Sub-word j of a filled line holds the byte at its sub-word-0 address + j × 2^cfgStLog2, so consecutive fill reads are spaced by the stride. memAddr and memWe hold steady while memReq is high and memAck is low.
- R5: Line and sub-word placement follow only reqPline/reqPword. With 4 sub-words, start 8, 4 lines, virtual length 2, stride 2 and mask 0, loads of 0,2,…,18 miss only at 0 and 16. With start 0 and mask 4, the same loads miss only at 0 and 12.
- R6: All memory reads and writes use unperturbed addresses (memory address arithmetic wraps modulo 2^AW), and a load returns the memory byte at its own unperturbed address.
- R7: A store hit writes reqWdata into the addressed sub-word and marks the line dirty, and a following load of that address hits and returns the stored byte. respRdata is defined only for loads.
- R8: Before a line of the fill group is refilled, the line is written back one byte per memory write, to its tag + j × stride for j = 0..WORDS-1, only if it is valid and dirty. Clean or invalid lines cause no memory writes.
- R9: An accepted request (reqValid and reqReady both 1 at a clock edge) drops reqReady in the next cycle. Exactly one single-cycle respValid pulse answers each request, with no memory request in that cycle, and reqReady returns 1 in the cycle after the pulse.
- R10: A store miss first fills the virtual line, then writes the byte, reports respHit 0, and a later load of that address hits with the stored byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Core presents an access |
| reqReady | output | 1 | Block can accept an access this cycle |
| reqWrite | input | 1 | 1 for store, 0 for load |
| reqAddr | input | AW | Unperturbed byte address |
| reqWdata | input | 8 | Store byte |
| reqPline | input | log2(LINES) | Partition-relative line from translation |
| reqPword | input | log2(WORDS) | Sub-word index from translation |
| cfgStart | input | log2(LINES) | First physical line of the partition |
| cfgVsLog2 | input | clog2(log2(LINES)+1) | log2 of physical lines per virtual line |
| cfgStLog2 | input | clog2(AW) | log2 of the sub-word stride in bytes |
| respValid | output | 1 | Single-cycle response strobe |
| respHit | output | 1 | 1 if the access hit without a fill |
| respRdata | output | 8 | Load data |
| memReq | output | 1 | Memory access request, held until memAck |
| memWe | output | 1 | 1 for write-back, 0 for fill read |
| memAddr | output | AW | Memory byte address |
| memWdata | output | 8 | Write-back byte |
| memAck | input | 1 | Memory completes the access this cycle |
| memRdata | input | 8 | Read byte, valid with memAck |

## Verification
The bench uses the defaults LINES=16, WORDS=4 and AW=16, and drives a stride of 2 with virtual lines of two physical lines. Two partitions occupy disjoint line ranges, one with mask 0 and one with mask 4, which brings both stated miss patterns within reach. The mask-4 partition forces a fill that begins below address zero, so memory address wrap-around is exercised. A store followed by a conflicting miss reaches a group that holds one dirty line and one clean line, and the written-back byte is later read back through the cache. A store miss on a fresh group covers write-allocate.

// File: rtl/pcache_pkg.sv
package pcache_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_NEXT,
    ST_WB,
    ST_FILL
  } state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latch;     // capture request, clear counters
    logic hitOp;     // perform store on hit line
    logic setMiss;   // remember that a fill was needed
    logic wordStep;  // advance sub-word counter
    logic fillWrite; // write fill byte
    logic lineDone;  // mark group line valid and clean
    logic wbSel;     // memory address from write-back path
  } strobe_t;

endpackage

// File: rtl/pcache_dp.sv
module pcache_dp
  import pcache_pkg::*;
#(
  parameter int LINES = 16,
  parameter int WORDS = 4,
  parameter int AW    = 16,
  localparam int LW   = $clog2(LINES),
  localparam int WW   = $clog2(WORDS),
  localparam int VSW  = $clog2(LW + 1),
  localparam int SW   = $clog2(AW)
) (
  input  logic           clk,
  input  logic           rstN,
  input  strobe_t        stb,
  input  logic           reqWrite,
  input  logic [AW-1:0]  reqAddr,
  input  logic [7:0]     reqWdata,
  input  logic [LW-1:0]  reqPline,
  input  logic [WW-1:0]  reqPword,
  input  logic [LW-1:0]  cfgStart,
  input  logic [VSW-1:0] cfgVsLog2,
  input  logic [SW-1:0]  cfgStLog2,
  input  logic [7:0]     memRdata,
  output logic           hit,
  output logic           lineDirty,
  output logic           lastWord,
  output logic           lastLine,
  output logic           respHit,
  output logic [7:0]     respRdata,
  output logic [AW-1:0]  memAddr,
  output logic [7:0]     memWdata
);

  logic [7:0]    dataArr [LINES][WORDS];
  logic [AW-1:0] tagArr  [LINES];
  logic [LINES-1:0] validArr, dirtyArr;

  logic          aWrite;
  logic [AW-1:0] aAddr, grpBase;
  logic [7:0]    aWdata;
  logic [LW-1:0] aStart, aPline;
  logic [WW-1:0] aPword;
  logic [VSW-1:0] aVs;
  logic [SW-1:0] aSt;
  logic [LW:0]   gCnt;
  logic [WW-1:0] jCnt;
  logic          missSeen;

  // group offset of the requested line, measured in sub-words
  logic [LW-1:0] reqOff;
  logic [AW-1:0] reqBase;
  assign reqOff  = reqPline & ((LW'(1) << cfgVsLog2) - LW'(1));
  assign reqBase = reqAddr - (AW'({reqOff, reqPword}) << cfgStLog2);

  logic [LW-1:0] curLine, grpLine, lineG;
  assign curLine = aStart + aPline;
  assign grpLine = aStart + (aPline & ~((LW'(1) << aVs) - LW'(1)));
  assign lineG   = grpLine + gCnt[LW-1:0];

  logic [AW-1:0] wantTag, fillAddr, wbAddr, lineTag;
  assign wantTag  = aAddr - (AW'(aPword) << aSt);
  assign fillAddr = grpBase + (AW'({gCnt, jCnt}) << aSt);
  assign lineTag  = grpBase + (AW'({gCnt, {WW{1'b0}}}) << aSt);
  assign wbAddr   = tagArr[lineG] + (AW'(jCnt) << aSt);

  assign hit       = validArr[curLine] && (tagArr[curLine] == wantTag);
  assign lineDirty = validArr[lineG] && dirtyArr[lineG];
  assign lastWord  = (jCnt == WW'(WORDS - 1));
  assign lastLine  = (gCnt == (((LW+1)'(1) << aVs) - (LW+1)'(1)));
  assign respHit   = !missSeen;
  assign respRdata = dataArr[curLine][aPword];
  assign memAddr   = stb.wbSel ? wbAddr : fillAddr;
  assign memWdata  = dataArr[lineG][jCnt];

  always_ff @(posedge clk) begin
    if (stb.latch) begin
      aWrite  <= reqWrite;
      aAddr   <= reqAddr;
      aWdata  <= reqWdata;
      aStart  <= cfgStart;
      aPline  <= reqPline;
      aPword  <= reqPword;
      aVs     <= cfgVsLog2;
      aSt     <= cfgStLog2;
      grpBase <= reqBase;
    end
    if (stb.fillWrite) dataArr[lineG][jCnt] <= memRdata;
    if (stb.hitOp && aWrite) dataArr[curLine][aPword] <= aWdata;
    if (stb.lineDone) tagArr[lineG] <= lineTag;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validArr <= '0;
      dirtyArr <= '0;
      gCnt     <= '0;
      jCnt     <= '0;
      missSeen <= 1'b0;
    end else begin
      if (stb.latch) begin
        gCnt     <= '0;
        jCnt     <= '0;
        missSeen <= 1'b0;
      end
      if (stb.setMiss) missSeen <= 1'b1;
      if (stb.wordStep) jCnt <= lastWord ? '0 : jCnt + WW'(1);
      if (stb.lineDone) begin
        validArr[lineG] <= 1'b1;
        dirtyArr[lineG] <= 1'b0;
        gCnt            <= gCnt + (LW+1)'(1);
      end
      if (stb.hitOp && aWrite) dirtyArr[curLine] <= 1'b1;
    end
  end

endmodule

// File: rtl/pcache_ctrl.sv
module pcache_ctrl
  import pcache_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    hit,
  input  logic    lineDirty,
  input  logic    lastWord,
  input  logic    lastLine,
  input  logic    memAck,
  output logic    reqReady,
  output logic    respValid,
  output logic    memReq,
  output logic    memWe,
  output strobe_t stb
);

  state_t state, stateNxt;

  always_comb begin
    stateNxt = state;
    stb      = '0;
    case (state)
      ST_IDLE: if (reqValid) begin
        stb.latch = 1'b1;
        stateNxt  = ST_LOOK;
      end
      ST_LOOK: begin
        if (hit) begin
          stb.hitOp = 1'b1;
          stateNxt  = ST_IDLE;
        end else begin
          stb.setMiss = 1'b1;
          stateNxt    = ST_NEXT;
        end
      end
      ST_NEXT: stateNxt = lineDirty ? ST_WB : ST_FILL;
      ST_WB: begin
        stb.wbSel = 1'b1;
        if (memAck) begin
          stb.wordStep = 1'b1;
          if (lastWord) stateNxt = ST_FILL;
        end
      end
      ST_FILL: if (memAck) begin
        stb.wordStep  = 1'b1;
        stb.fillWrite = 1'b1;
        if (lastWord) begin
          stb.lineDone = 1'b1;
          stateNxt     = lastLine ? ST_LOOK : ST_NEXT;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  assign reqReady  = (state == ST_IDLE);
  assign respValid = (state == ST_LOOK) && hit;
  assign memReq    = (state == ST_WB) || (state == ST_FILL);
  assign memWe     = (state == ST_WB);

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

endmodule

// File: rtl/pcache.sv
module pcache
  import pcache_pkg::*;
#(
  parameter int LINES = 16,
  parameter int WORDS = 4,
  parameter int AW    = 16,
  localparam int LW   = $clog2(LINES),
  localparam int WW   = $clog2(WORDS),
  localparam int VSW  = $clog2(LW + 1),
  localparam int SW   = $clog2(AW)
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           reqValid,
  output logic           reqReady,
  input  logic           reqWrite,
  input  logic [AW-1:0]  reqAddr,
  input  logic [7:0]     reqWdata,
  input  logic [LW-1:0]  reqPline,
  input  logic [WW-1:0]  reqPword,
  input  logic [LW-1:0]  cfgStart,
  input  logic [VSW-1:0] cfgVsLog2,
  input  logic [SW-1:0]  cfgStLog2,
  output logic           respValid,
  output logic           respHit,
  output logic [7:0]     respRdata,
  output logic           memReq,
  output logic           memWe,
  output logic [AW-1:0]  memAddr,
  output logic [7:0]     memWdata,
  input  logic           memAck,
  input  logic [7:0]     memRdata
);

  strobe_t stb;
  logic hit, lineDirty, lastWord, lastLine;

  pcache_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .hit(hit),
    .lineDirty(lineDirty), .lastWord(lastWord), .lastLine(lastLine),
    .memAck(memAck), .reqReady(reqReady), .respValid(respValid),
    .memReq(memReq), .memWe(memWe), .stb(stb)
  );

  pcache_dp #(.LINES(LINES), .WORDS(WORDS), .AW(AW)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqPline(reqPline),
    .reqPword(reqPword), .cfgStart(cfgStart), .cfgVsLog2(cfgVsLog2),
    .cfgStLog2(cfgStLog2), .memRdata(memRdata), .hit(hit),
    .lineDirty(lineDirty), .lastWord(lastWord), .lastLine(lastLine),
    .respHit(respHit), .respRdata(respRdata), .memAddr(memAddr),
    .memWdata(memWdata)
  );

endmodule

// File: rtl/pcache_chk.sv
module pcache_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rstN,
  input logic          reqValid,
  input logic          reqReady,
  input logic          respValid,
  input logic          memReq,
  input logic          memWe,
  input logic [AW-1:0] memAddr,
  input logic          memAck
);

  assert_mem_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !memReq);

  assert_ready_drop_R9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  assert_resp_release_R9: assert property (@(posedge clk) disable iff (!rstN)
    respValid |=> (reqReady && !respValid));

  assert_resp_no_mem_R9: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> !memReq);

  assert_mem_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWe)));

endmodule

bind pcache pcache_chk #(.AW(AW)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .respValid(respValid), .memReq(memReq), .memWe(memWe),
  .memAddr(memAddr), .memAck(memAck)
);

// File: tb/pcache_tb.sv
module pcache_tb;

  localparam int LINES = 16, WORDS = 4, AW = 16;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [15:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic [3:0]  reqPline = '0, cfgStart = '0;
  logic [1:0]  reqPword = '0;
  logic [2:0]  cfgVsLog2 = '0;
  logic [3:0]  cfgStLog2 = '0;
  logic reqReady, respValid, respHit, memReq, memWe;
  logic [7:0] respRdata, memWdata;
  logic [15:0] memAddr;
  logic memAck = 1'b0;
  logic [7:0] memRdata = '0;

  always #4 clk = ~clk;

  pcache #(.LINES(LINES), .WORDS(WORDS), .AW(AW)) u_dut (.*);

  int nChecks = 0, nFail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // memory model: sparse store over a computed background
  logic [7:0] memStore [int];
  logic [7:0] shadow [int];
  function automatic logic [7:0] bg(input logic [15:0] a);
    return a[7:0] ^ (a[15:8] * 8'd3) ^ 8'h5A;
  endfunction
  function automatic logic [7:0] memVal(input logic [15:0] a);
    return memStore.exists(int'(a)) ? memStore[int'(a)] : bg(a);
  endfunction
  function automatic logic [7:0] expVal(input logic [15:0] a);
    return shadow.exists(int'(a)) ? shadow[int'(a)] : bg(a);
  endfunction

  int rdCnt = 0, wrCnt = 0;
  logic [15:0] rdLog [$];
  logic [15:0] wrLog [$];
  always @(posedge clk) begin
    if (memReq && !memAck) begin
      memAck <= 1'b1;
      if (memWe) begin
        memStore[int'(memAddr)] = memWdata;
        wrLog.push_back(memAddr);
        wrCnt++;
      end else begin
        memRdata <= memVal(memAddr);
        rdLog.push_back(memAddr);
        rdCnt++;
      end
    end else memAck <= 1'b0;
  end

  // partition configuration and translation neighbour model
  int pStart, pSize, pVs, pSt, pMask;
  task automatic setPart(input int st, input int ps, input int vs,
                         input int sl, input int mk);
    pStart = st; pSize = ps; pVs = vs; pSt = sl; pMask = mk;
  endtask

  // scoreboard
  typedef struct { bit isLoad; bit hit; logic [7:0] data; string req; } exp_t;
  exp_t sbq [$];

  always @(negedge clk) begin
    if (respValid) begin
      if (sbq.size() == 0) chk(0, "R9", "unexpected response", 1, 0);
      else begin
        exp_t e;
        e = sbq.pop_front();
        chk(respHit == e.hit, e.req, "hit flag", respHit, e.hit);
        if (e.isLoad) chk(respRdata == e.data, e.req, "load data", respRdata, e.data);
      end
    end
  end

  task automatic access(input logic [15:0] a, input bit we, input logic [7:0] wd,
                        input bit expHit, input string req);
    exp_t e;
    logic [15:0] pa;
    int q;
    pa = a + 16'(pMask);
    q  = int'(pa >> pSt);
    e.isLoad = !we; e.hit = expHit; e.data = expVal(a); e.req = req;
    sbq.push_back(e);
    if (we) shadow[int'(a)] = wd;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = we; reqAddr = a; reqWdata = wd;
    reqPline = 4'((q / WORDS) % pSize); reqPword = 2'(q % WORDS);
    cfgStart = 4'(pStart); cfgVsLog2 = 3'(pVs); cfgStLog2 = 4'(pSt);
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    chk(reqReady == 1'b0, "R9", "ready after accept", reqReady, 0);
    while (sbq.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      done = 1;
      nChecks++; nFail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    int r0, w0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady == 1'b1, "R1", "reset ready", reqReady, 1);
    chk(respValid == 1'b0, "R1", "reset respValid", respValid, 0);
    chk(memReq == 1'b0, "R1", "reset memReq", memReq, 0);

    // partition A: start 8, 4 lines, vline 2, stride 2, mask 0
    setPart(8, 4, 1, 1, 0);
    r0 = rdCnt;
    access(16'd0, 0, 8'h00, 0, "R1");
    chk(rdCnt - r0 == 8, "R3", "reads per miss", rdCnt - r0, 8);
    for (int k = 0; k < 8; k++)
      chk(rdLog[r0 + k] == 16'(2 * k), "R4", "strided fill addr", rdLog[r0 + k], 2 * k);
    for (int a = 2; a <= 18; a += 2)
      access(16'(a), 0, 8'h00, a != 16, "R5");

    // partition B: start 0, mask 4
    setPart(0, 4, 1, 1, 4);
    r0 = rdCnt;
    for (int a = 0; a <= 18; a += 2)
      access(16'(a), 0, 8'h00, (a != 0) && (a != 12), "R5");
    chk(rdLog[r0] == 16'hFFFC, "R6", "unperturbed fill start", rdLog[r0], 16'hFFFC);
    chk(rdLog[r0 + 2] == 16'h0000, "R6", "fill addr 2", rdLog[r0 + 2], 0);
    chk(wrCnt == 0, "R8", "no writes for clean lines", wrCnt, 0);

    // store hit then read back (partition A)
    setPart(8, 4, 1, 1, 0);
    access(16'd4, 1, 8'h3C, 1, "R7");
    access(16'd4, 0, 8'h00, 1, "R7");
    access(16'd8, 0, 8'h00, 1, "R2");

    // conflicting miss evicts dirty line 8, clean line 9
    r0 = rdCnt; w0 = wrCnt;
    access(16'd32, 0, 8'h00, 0, "R2");
    chk(wrCnt - w0 == 4, "R8", "write-back count", wrCnt - w0, 4);
    for (int k = 0; k < 4; k++)
      chk(wrLog[w0 + k] == 16'(2 * k), "R8", "write-back addr", wrLog[w0 + k], 2 * k);
    chk(memVal(16'd4) == 8'h3C, "R8", "written-back byte", memVal(16'd4), 8'h3C);
    chk(rdCnt - r0 == 8, "R3", "reads after write-back", rdCnt - r0, 8);

    // reload the evicted byte through memory
    w0 = wrCnt;
    access(16'd4, 0, 8'h00, 0, "R6");
    chk(wrCnt == w0, "R8", "clean eviction writes", wrCnt - w0, 0);

    // store miss allocates
    r0 = rdCnt;
    access(16'd50, 1, 8'h77, 0, "R10");
    chk(rdCnt - r0 == 8, "R10", "allocate fill reads", rdCnt - r0, 8);
    access(16'd50, 0, 8'h00, 1, "R10");
    access(16'd48, 0, 8'h00, 1, "R10");

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

endmodule